// File: doc/BRIEF.md
# Flash Toggle-Bit Completion Poller

This block sits on the host side of a NOR flash interface and decides whether an erase or program operation that has already been launched has finished. After a `start` pulse it reads the status byte through a request/acknowledge read port. It compares one toggling status bit across consecutive reads. If the bit toggles, it also consults the exceeded-timing bit to decide whether to keep polling, re-check, or give up.

A verdict comes out as a one-cycle `done` pulse with exactly one of `pass` or `fail`. Before a failure is reported, the poller raises a reset-command write request and waits for its acknowledge, so the device is back in array-read mode by the time software sees `fail`. A parameter picks which status bit is treated as the toggle bit. The default is bit 6. The sector-specific erase indicator at bit 2 is the alternative. The exceeded-timing bit is bit 5.

Top module: `flash_done_poller`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `rd_req`, `rst_cmd_req`, `done`, `pass` and `fail` are all low.
- R2: A `start` pulse makes `rd_req` high on the next cycle, and `rd_req` stays high until a cycle in which `rd_ack` is high.
- R3: Reads are taken in pairs. When the toggle bit matches between the first and second read of a pair, the poller reports `pass` after exactly two reads, with `done` high in the cycle after the second acknowledge.
- R4: When the toggle bit differs within a pair and bit 5 of the second read is 0, the poller starts a new pair of reads and reports nothing yet.
- R5: When the toggle bit differs and bit 5 of the second read is 1, the poller takes two more reads. If their toggle bits match, it reports `pass`.
- R6: If the toggle bits of that extra pair still differ, the poller raises `rst_cmd_req` and holds it until `rst_cmd_ack`. No read is requested meanwhile, and `rd_req` and `rst_cmd_req` are never high together.
- R7: A failure is reported only in the cycle after `rst_cmd_ack` was seen with `rst_cmd_req` high, as `done`=1, `fail`=1, `pass`=0.
- R8: `done` lasts exactly one cycle. `pass` and `fail` are high only together with `done`, and exactly one of them is high then.
- R9: A `start` pulse during polling abandons the earlier reads. The poller restarts with a fresh first read and does not reuse any stored toggle value.
- R10: With the parameter `SECTOR_BIT`=1, bit 2 is the toggle bit and bit 6 is ignored. With `SECTOR_BIT`=0, bit 6 is the toggle bit and bit 2 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin (or restart) polling |
| rd_req | output | 1 | Status read request, held until acknowledged |
| rd_ack | input | 1 | Read acknowledge; `rd_data` valid in this cycle |
| rd_data | input | DATA_W | Status byte returned by the read |
| rst_cmd_req | output | 1 | Request to write the reset command, held until acknowledged |
| rst_cmd_ack | input | 1 | Reset-command write acknowledge |
| done | output | 1 | One-cycle verdict strobe |
| pass | output | 1 | Operation completed, valid with `done` |
| fail | output | 1 | Operation timed out, valid with `done` |

## Verification
The delicate coincidence is a toggle bit that is still toggling in the same read where the exceeded-timing bit rises. Then one pair carries two facts, and the verdict depends on the following pair. The bench sweeps every combination of toggle and timing bits over the first four reads, under several acknowledge latencies, so that this case lands on each pair position. The outcome, the number of reads and the number of reset commands are judged against an arithmetic model of the polling rules. A second collision is a restart `start` arriving while a read is still waiting for its acknowledge. This is provoked directly, and the bench expects a clean two-read pass with no stale comparison.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_PAIR_A = 3'd1,
    ST_PAIR_B = 3'd2,
    ST_CHK_A  = 3'd3,
    ST_CHK_B  = 3'd4,
    ST_ABORT  = 3'd5
  } poll_st_t;

  typedef enum logic [1:0] {
    VD_NONE = 2'd0,
    VD_PASS = 2'd1,
    VD_FAIL = 2'd2
  } verdict_t;

  function automatic logic is_read_state(input poll_st_t s);
    return (s == ST_PAIR_A) || (s == ST_PAIR_B) || (s == ST_CHK_A) || (s == ST_CHK_B);
  endfunction

endpackage

// File: rtl/poll_bit_tap.sv
module poll_bit_tap #(
  parameter int DATA_W     = 8,
  parameter bit SECTOR_BIT = 1'b0,
  parameter int STD_POS    = 6,
  parameter int SECT_POS   = 2,
  parameter int TMO_POS    = 5
) (
  input  logic [DATA_W-1:0] data,
  output logic              tgl_bit,
  output logic              tmo_bit
);
  generate
    if (SECTOR_BIT) begin : g_sector
      assign tgl_bit = data[SECT_POS];
    end else begin : g_std
      assign tgl_bit = data[STD_POS];
    end
  endgenerate

  assign tmo_bit = data[TMO_POS];
endmodule

// File: rtl/poll_toggle_cmp.sv
module poll_toggle_cmp (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic load,
  input  logic sample,
  output logic differs
);
  logic held_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      held_q <= 1'b0;
    end else if (load) begin
      held_q <= sample;
    end
  end

  assign differs = held_q ^ sample;
endmodule

// File: rtl/poll_ctrl.sv
module poll_ctrl
  import flash_poll_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     start,
  input  logic     rd_ack,
  input  logic     rst_cmd_ack,
  input  logic     differs,
  input  logic     tmo_bit,
  output poll_st_t st,
  output logic     cap,
  output logic     clr,
  output verdict_t verdict
);
  poll_st_t nxt;

  always_comb begin
    nxt     = st;
    cap     = 1'b0;
    clr     = 1'b0;
    verdict = VD_NONE;
    if (start) begin
      nxt = ST_PAIR_A;
      clr = 1'b1;
    end else begin
      case (st)
        ST_PAIR_A: if (rd_ack) begin
          cap = 1'b1;
          nxt = ST_PAIR_B;
        end
        ST_PAIR_B: if (rd_ack) begin
          if (!differs) begin
            verdict = VD_PASS;
            nxt     = ST_IDLE;
          end else if (tmo_bit) begin
            nxt = ST_CHK_A;
          end else begin
            nxt = ST_PAIR_A;
          end
        end
        ST_CHK_A: if (rd_ack) begin
          cap = 1'b1;
          nxt = ST_CHK_B;
        end
        ST_CHK_B: if (rd_ack) begin
          if (!differs) begin
            verdict = VD_PASS;
            nxt     = ST_IDLE;
          end else begin
            nxt = ST_ABORT;
          end
        end
        ST_ABORT: if (rst_cmd_ack) begin
          verdict = VD_FAIL;
          nxt     = ST_IDLE;
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= nxt;
  end
endmodule

// File: rtl/poll_result.sv
module poll_result
  import flash_poll_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  verdict_t verdict,
  output logic     done,
  output logic     pass,
  output logic     fail
);
  always_ff @(posedge clk) begin
    if (rst) begin
      done <= 1'b0;
      pass <= 1'b0;
      fail <= 1'b0;
    end else begin
      done <= (verdict != VD_NONE);
      pass <= (verdict == VD_PASS);
      fail <= (verdict == VD_FAIL);
    end
  end
endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller
  import flash_poll_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter bit SECTOR_BIT = 1'b0,
  parameter int STD_POS    = 6,
  parameter int SECT_POS   = 2,
  parameter int TMO_POS    = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              rd_req,
  input  logic              rd_ack,
  input  logic [DATA_W-1:0] rd_data,
  output logic              rst_cmd_req,
  input  logic              rst_cmd_ack,
  output logic              done,
  output logic              pass,
  output logic              fail
);
  localparam int MAX_POS = (STD_POS > SECT_POS) ? ((STD_POS > TMO_POS) ? STD_POS : TMO_POS)
                                                : ((SECT_POS > TMO_POS) ? SECT_POS : TMO_POS);

  initial begin
    if (MAX_POS >= DATA_W) $error("bit position outside the status word");
  end

  logic     tgl_bit, tmo_bit, differs, cap, clr;
  poll_st_t st;
  verdict_t verdict;

  poll_bit_tap #(
    .DATA_W(DATA_W), .SECTOR_BIT(SECTOR_BIT), .STD_POS(STD_POS),
    .SECT_POS(SECT_POS), .TMO_POS(TMO_POS)
  ) u_tap (
    .data(rd_data), .tgl_bit(tgl_bit), .tmo_bit(tmo_bit)
  );

  poll_toggle_cmp u_cmp (
    .clk(clk), .rst(rst), .clear(clr), .load(cap && rd_ack),
    .sample(tgl_bit), .differs(differs)
  );

  poll_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .rd_ack(rd_ack),
    .rst_cmd_ack(rst_cmd_ack), .differs(differs), .tmo_bit(tmo_bit),
    .st(st), .cap(cap), .clr(clr), .verdict(verdict)
  );

  poll_result u_res (
    .clk(clk), .rst(rst), .verdict(verdict),
    .done(done), .pass(pass), .fail(fail)
  );

  assign rd_req      = is_read_state(st);
  assign rst_cmd_req = (st == ST_ABORT);
endmodule

// File: rtl/flash_done_poller_chk.sv
module flash_done_poller_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic rd_req,
  input logic rd_ack,
  input logic rst_cmd_req,
  input logic rst_cmd_ack,
  input logic done,
  input logic pass,
  input logic fail
);
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!rd_req && !rst_cmd_req && !done && !pass && !fail));

  p_start_req_r2: assert property (@(posedge clk) disable iff (rst)
    start |=> rd_req);

  p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_ack && !start) |=> rd_req);

  p_cmd_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (rst_cmd_req && !rst_cmd_ack && !start) |=> rst_cmd_req);

  p_bus_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(rd_req && rst_cmd_req));

  p_fail_after_ack_r7: assert property (@(posedge clk) disable iff (rst)
    fail |-> $past(rst_cmd_req && rst_cmd_ack && !start));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_verdict_onehot_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> $onehot({pass, fail}));

  p_verdict_gated_r8: assert property (@(posedge clk) disable iff (rst)
    (pass || fail) |-> done);
endmodule

bind flash_done_poller flash_done_poller_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .rd_req(rd_req), .rd_ack(rd_ack),
  .rst_cmd_req(rst_cmd_req), .rst_cmd_ack(rst_cmd_ack),
  .done(done), .pass(pass), .fail(fail)
);

// File: tb/flash_done_poller_bench.sv
module flash_done_poller_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rd_req_a, rd_ack_a = 1'b0, cmd_req_a, cmd_ack_a = 1'b0, done_a, pass_a, fail_a;
  logic rd_req_b, rd_ack_b = 1'b0, cmd_req_b, cmd_ack_b = 1'b0, done_b, pass_b, fail_b;
  logic [7:0] rd_data_a = 8'h0, rd_data_b = 8'h0;

  flash_done_poller #(.SECTOR_BIT(1'b0)) u_flash_done_poller (
    .clk(clk), .rst(rst), .start(start), .rd_req(rd_req_a), .rd_ack(rd_ack_a),
    .rd_data(rd_data_a), .rst_cmd_req(cmd_req_a), .rst_cmd_ack(cmd_ack_a),
    .done(done_a), .pass(pass_a), .fail(fail_a));

  flash_done_poller #(.SECTOR_BIT(1'b1)) u_flash_done_poller_sect (
    .clk(clk), .rst(rst), .start(start), .rd_req(rd_req_b), .rd_ack(rd_ack_b),
    .rd_data(rd_data_b), .rst_cmd_req(cmd_req_b), .rst_cmd_ack(cmd_ack_b),
    .done(done_b), .pass(pass_b), .fail(fail_b));

  int checks = 0, fails = 0;
  int code_r = 0, lat_r = 0;
  int idx_a = 0, wait_a = 0, cwait_a = 0, cmds_a = 0;
  int idx_b = 0, wait_b = 0, cwait_b = 0, cmds_b = 0;
  bit pend_a = 0, pend_b = 0, prevdone_a = 0, prevdone_b = 0;
  bit got_a = 0, got_b = 0, gpass_a = 0, gfail_a = 0, gpass_b = 0, gfail_b = 0;
  int greads_a = 0, greads_b = 0, gcmds_a = 0, gcmds_b = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Script: reads 0..3 carry toggle bit = code[2k], timing bit = code[2k+1]; later reads steady.
  function automatic bit t_of(input int code, input int k);
    return (k < 4) ? 1'((code >> (2*k)) & 1) : 1'b0;
  endfunction
  function automatic bit o_of(input int code, input int k);
    return (k < 4) ? 1'((code >> (2*k+1)) & 1) : 1'b0;
  endfunction
  function automatic logic [7:0] rd_byte(input int code, input int k, input bit sect);
    logic [7:0] b;
    b = 8'h01;
    b[5] = o_of(code, k);
    b[7] = 1'(k >> 1);
    if (sect) begin b[2] = t_of(code, k); b[6] = 1'(k); end
    else      begin b[6] = t_of(code, k); b[2] = 1'(k); end
    return b;
  endfunction

  // Arithmetic model of the polling rules; path = requirement exercised.
  function automatic void model(input int code, output bit ok, output int reads, output int path);
    int i;
    bit x, y, o;
    i = 0; ok = 1'b0; reads = 0; path = 3;
    for (int g = 0; g < 10; g++) begin
      x = t_of(code, i); y = t_of(code, i+1); o = o_of(code, i+1);
      i += 2;
      if (x == y) begin ok = 1'b1; reads = i; return; end
      if (o) begin
        x = t_of(code, i); y = t_of(code, i+1);
        i += 2;
        ok = (x == y); reads = i; path = ok ? 5 : 7;
        return;
      end
      path = 4;
    end
  endfunction

  always @(negedge clk) begin
    rd_ack_a = 1'b0; cmd_ack_a = 1'b0;
    rd_ack_b = 1'b0; cmd_ack_b = 1'b0;
    if (!rst) begin
      if (pend_a) check(rd_req_a, "R2 read request held (bit6)", rd_req_a, 1);
      if (pend_b) check(rd_req_b, "R2 read request held (bit2)", rd_req_b, 1);
      if (cmd_req_a) check(!rd_req_a, "R6 no read during reset command", rd_req_a, 0);
      if (cmd_req_b) check(!rd_req_b, "R6 no read during reset command", rd_req_b, 0);
      if (rd_req_a) begin
        if (wait_a < lat_r) wait_a++;
        else begin rd_ack_a = 1'b1; rd_data_a = rd_byte(code_r, idx_a, 1'b0); idx_a++; wait_a = 0; end
      end
      if (rd_req_b) begin
        if (wait_b < lat_r) wait_b++;
        else begin rd_ack_b = 1'b1; rd_data_b = rd_byte(code_r, idx_b, 1'b1); idx_b++; wait_b = 0; end
      end
      if (cmd_req_a) begin
        if (cwait_a < lat_r) cwait_a++;
        else begin cmd_ack_a = 1'b1; cmds_a++; cwait_a = 0; end
      end
      if (cmd_req_b) begin
        if (cwait_b < lat_r) cwait_b++;
        else begin cmd_ack_b = 1'b1; cmds_b++; cwait_b = 0; end
      end
      pend_a = rd_req_a && !rd_ack_a;
      pend_b = rd_req_b && !rd_ack_b;
      if (prevdone_a) check(!done_a, "R8 done one cycle", done_a, 0);
      if (prevdone_b) check(!done_b, "R8 done one cycle", done_b, 0);
      if (done_a) begin
        check(pass_a != fail_a, "R8 exactly one verdict", {pass_a, fail_a}, 1);
        got_a = 1; gpass_a = pass_a; gfail_a = fail_a; greads_a = idx_a; gcmds_a = cmds_a;
      end
      if (done_b) begin
        check(pass_b != fail_b, "R8 exactly one verdict", {pass_b, fail_b}, 1);
        got_b = 1; gpass_b = pass_b; gfail_b = fail_b; greads_b = idx_b; gcmds_b = cmds_b;
      end
      prevdone_a = done_a;
      prevdone_b = done_b;
    end
  end

  task automatic clear_run();
    idx_a = 0; wait_a = 0; cwait_a = 0; cmds_a = 0; got_a = 0;
    idx_b = 0; wait_b = 0; cwait_b = 0; cmds_b = 0; got_b = 0;
  endtask

  task automatic wait_done();
    int n;
    n = 0;
    while (!(got_a && got_b) && n < 300) begin @(negedge clk); n++; end
    check(got_a && got_b, "R3 verdict reached", {got_a, got_b}, 3);
    @(negedge clk); @(negedge clk);
  endtask

  task automatic judge(input string tag, input bit gp, input bit gf, input int gr, input int gc,
                       input bit ok, input int reads);
    check(gp == ok, {tag, " pass flag"}, gp, ok);
    check(gf == !ok, {tag, " fail flag (R7)"}, gf, !ok);
    check(gr == reads, {tag, " read count"}, gr, reads);
    check(gc == (ok ? 0 : 1), {tag, " reset commands (R6)"}, gc, ok ? 0 : 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    bit ok;
    int reads, path;
    string tag;
    repeat (3) @(negedge clk);
    check({rd_req_a, cmd_req_a, done_a, pass_a, fail_a} == 5'b0, "R1 reset idle (bit6)",
          {rd_req_a, cmd_req_a, done_a, pass_a, fail_a}, 0);
    check({rd_req_b, cmd_req_b, done_b, pass_b, fail_b} == 5'b0, "R1 reset idle (bit2)",
          {rd_req_b, cmd_req_b, done_b, pass_b, fail_b}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!rd_req_a && !done_a, "R1 idle after reset", {rd_req_a, done_a}, 0);

    for (int code = 0; code < 256; code++) begin
      code_r = code; lat_r = code % 3;
      clear_run();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done();
      model(code, ok, reads, path);
      tag = (path == 3) ? "R3" : (path == 4) ? "R4" : (path == 5) ? "R5" : "R7";
      judge({tag, " bit6"}, gpass_a, gfail_a, greads_a, gcmds_a, ok, reads);
      judge({tag, " R10 bit2"}, gpass_b, gfail_b, greads_b, gcmds_b, ok, reads);
    end

    // R9: restart while the second read of a toggling pair is outstanding.
    code_r = 1; lat_r = 3;
    clear_run();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (idx_a < 1) @(negedge clk);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    judge("R9 restart bit6", gpass_a, gfail_a, greads_a, gcmds_a, 1'b1, 3);
    judge("R9 restart bit2", gpass_b, gfail_b, greads_b, gcmds_b, 1'b1, 3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule